// File: doc/BRIEF.md
# Descriptor-Chained Disk DMA Engine

This block is a bus-master DMA engine for a disk interface. Software builds a chain of 8-byte descriptors in system memory, writes the chain's base address into the table pointer register and sets the run bit. The engine then reads descriptors one at a time, each time only once the previous buffer is used up. While the drive holds its request line high, the engine moves 16-bit words between the buffer and the drive data port.

Three host registers control it: a command byte, a status byte and a 32-bit table pointer. A register write selects its target with `reg_addr`: 0 selects the command byte, 1 the status byte and 2 the table pointer. All three are always visible on output ports. The memory side is a word-wide request/acknowledge port. The drive side is a request input with a one-cycle word strobe.

A descriptor is four little-endian 16-bit words at increasing addresses. Words 0 and 1 hold the buffer byte address, with bit 0 forced to zero. Word 2 holds the byte length, with bit 0 cleared, and a length of zero means 65536 bytes. Bit 15 of word 3 marks the final descriptor.

Top module: `desc_dma_engine`

## Requirements
- R1: In the command byte, only bit 0 (run) and bit 3 (direction, 1 = drive to memory) take written values. All other command bits read as zero.
- R2: A write that changes run from 0 to 1 sets status bit 0 (active). It also clears the remaining byte count and restarts descriptor fetching at the table pointer, so a restarted transfer replays the chain from its first entry.
- R3: A write that changes run from 1 to 0 while active clears active. After the word in flight, no further drive strobes occur, even with the drive still requesting. Status bit 1 (error) stays 0.
- R4: Status bit 2 sets on each new rising edge of `drive_irq` and clears when it is written with 1. A level that stays high does not set it again.
- R5: Status bits 5 and 6 take written values. Writes to status bit 0 have no effect.
- R6: The table pointer always reads with its two low bits zero.
- R7: A descriptor is fetched as four word reads at pointer+0, +2, +4 and +6. The buffer address has bit 0 forced to zero and the length has bit 0 cleared. The next descriptor follows 8 bytes later.
- R8: A length field of zero moves 65536 bytes before that descriptor is finished.
- R9: With direction 0, each word is read from the buffer and presented on `drv_wdata` during a one-cycle `drv_ack`. Buffer addresses step by 2, and `drv_ack` never coincides with `mem_req`.
- R10: With direction 1, the engine samples `drv_rdata` on the edge that raises `drv_ack`. It then writes that word to the current buffer address.
- R11: No word moves and no descriptor is fetched while `drv_req` is low. A paused transfer resumes where it stopped.
- R12: When the final descriptor's count reaches zero, active clears, and a drive that keeps requesting gets no further strobes.
- R13: Once raised, `mem_req` and its address, write flag and write data stay unchanged until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | 2 | Register select: 0 command, 1 status, 2 table pointer |
| reg_wdata | input | 32 | Host write data (byte registers use bits 7:0) |
| cmd_reg | output | 8 | Command byte |
| sts_reg | output | 8 | Status byte |
| tbl_reg | output | 32 | Descriptor table pointer |
| drive_irq | input | 1 | Interrupt line from the drive |
| drv_req | input | 1 | Drive requests a word transfer |
| drv_ack | output | 1 | One-cycle word strobe to the drive |
| drv_rdata | input | 16 | Word from the drive |
| drv_wdata | output | 16 | Word to the drive, valid with drv_ack |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address (even) |
| mem_wdata | output | 16 | Memory write word |
| mem_rdata | input | 16 | Memory read word |
| mem_ack | input | 1 | Memory access complete |

## Verification
The read direction is tried on three chains:
- A two-entry chain with an odd address and odd length. This separates correct descriptor decoding and chaining from off-by-one masking.
- A single long entry stopped after three words and then restarted. This separates a pointer reload from a continuation of the old chain.
- A zero-length entry run for 40 words. This shows that zero is taken as the maximum and not as empty.

The write direction is tried with the drive request dropped halfway. This shows that work is gated by the request and resumes at the right address. Register patterns with every bit set show which bits are writable, which are write-one-to-clear and which are ignored. The interrupt input is tried both as a pulse and as a held level.

// File: rtl/dde_pkg.sv
package dde_pkg;
  // Host register selects
  localparam logic [1:0] SEL_CMD = 2'd0;
  localparam logic [1:0] SEL_STS = 2'd1;
  localparam logic [1:0] SEL_TBL = 2'd2;

  // Writable command bits: run (0) and direction (3)
  localparam logic [7:0] CMD_MASK = 8'h09;

  // Descriptor geometry
  localparam int DESC_BYTES = 8;
  localparam int LEN_W      = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_MRD,
    ST_DPUT,
    ST_DGET,
    ST_MWR
  } mover_st_e;
endpackage

// File: rtl/dde_regs.sv
module dde_regs
  import dde_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [ADDR_W-1:0] reg_wdata,
  input  logic              drive_irq,
  input  logic              xfer_done,
  output logic [7:0]        cmd_q,
  output logic [7:0]        sts_q,
  output logic [ADDR_W-1:0] tbl_q,
  output logic              start_pulse,
  output logic              active,
  output logic              to_mem
);
  logic       irq_prev;
  logic       irq_flag;
  logic [1:0] cap_bits;
  logic       wr_cmd, wr_sts, wr_tbl, stop_req;

  assign wr_cmd      = reg_wr && (reg_addr == SEL_CMD);
  assign wr_sts      = reg_wr && (reg_addr == SEL_STS);
  assign wr_tbl      = reg_wr && (reg_addr == SEL_TBL);
  assign start_pulse = wr_cmd && !cmd_q[0] && reg_wdata[0];
  assign stop_req    = wr_cmd && cmd_q[0] && !reg_wdata[0];
  assign to_mem      = cmd_q[3];
  assign sts_q       = {1'b0, cap_bits, 2'b00, irq_flag, 1'b0, active};

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q    <= '0;
      tbl_q    <= '0;
      active   <= 1'b0;
      irq_prev <= 1'b0;
      irq_flag <= 1'b0;
      cap_bits <= '0;
    end else begin
      irq_prev <= drive_irq;
      if (wr_cmd)
        cmd_q <= (cmd_q & ~CMD_MASK) | (reg_wdata[7:0] & CMD_MASK);
      if (start_pulse)
        active <= 1'b1;
      else if (stop_req || xfer_done)
        active <= 1'b0;
      if (drive_irq && !irq_prev)
        irq_flag <= 1'b1;
      else if (wr_sts && reg_wdata[2])
        irq_flag <= 1'b0;
      if (wr_sts)
        cap_bits <= reg_wdata[6:5];
      if (wr_tbl)
        tbl_q <= {reg_wdata[ADDR_W-1:2], 2'b00};
    end
  end
endmodule

// File: rtl/dde_mover.sv
module dde_mover
  import dde_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              active,
  input  logic              to_mem,
  input  logic [ADDR_W-1:0] tbl_ptr,
  input  logic              drv_req,
  input  logic [DATA_W-1:0] drv_rdata,
  output logic              drv_ack,
  output logic [DATA_W-1:0] drv_wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic              done
);
  localparam int WORD_BYTES = DATA_W / 8;
  localparam int DESC_WORDS = DESC_BYTES / WORD_BYTES;
  localparam int FIDX_W     = $clog2(DESC_WORDS);
  localparam int CNT_W      = LEN_W + 1;
  localparam int SR_W       = DATA_W * (DESC_WORDS - 1);

  mover_st_e         st;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] dptr;
  logic [ADDR_W-1:0] baddr;
  logic              last;
  logic [FIDX_W-1:0] fidx;
  logic [SR_W-1:0]   desc_sr;
  logic [LEN_W-1:0]  desc_len;
  logic              step_now;

  assign desc_len = desc_sr[32 +: LEN_W] & ~LEN_W'(1);
  assign step_now = (st == ST_DPUT) || (st == ST_MWR && mem_ack);
  assign done     = step_now && last && (cnt == CNT_W'(WORD_BYTES));

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      drv_ack   <= 1'b0;
      drv_wdata <= '0;
      cnt       <= '0;
      dptr      <= '0;
      baddr     <= '0;
      last      <= 1'b0;
      fidx      <= '0;
      desc_sr   <= '0;
    end else begin
      drv_ack <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (active && drv_req) begin
            if (cnt == '0) begin
              st       <= ST_FETCH;
              mem_req  <= 1'b1;
              mem_we   <= 1'b0;
              mem_addr <= dptr;
              fidx     <= '0;
            end else if (to_mem) begin
              st        <= ST_DGET;
              drv_ack   <= 1'b1;
              mem_wdata <= drv_rdata;
            end else begin
              st       <= ST_MRD;
              mem_req  <= 1'b1;
              mem_we   <= 1'b0;
              mem_addr <= baddr;
            end
          end
        end
        ST_FETCH: begin
          if (mem_ack) begin
            if (fidx == FIDX_W'(DESC_WORDS - 1)) begin
              mem_req <= 1'b0;
              st      <= ST_IDLE;
              baddr   <= desc_sr[ADDR_W-1:0] & ~ADDR_W'(1);
              cnt     <= (desc_len == '0) ? (CNT_W'(1) << LEN_W) : CNT_W'(desc_len);
              last    <= mem_rdata[DATA_W-1];
              dptr    <= dptr + ADDR_W'(DESC_BYTES);
            end else begin
              desc_sr  <= {mem_rdata, desc_sr[SR_W-1:DATA_W]};
              fidx     <= fidx + 1'b1;
              mem_addr <= mem_addr + ADDR_W'(WORD_BYTES);
            end
          end
        end
        ST_MRD: begin
          if (mem_ack) begin
            mem_req   <= 1'b0;
            drv_wdata <= mem_rdata;
            drv_ack   <= 1'b1;
            st        <= ST_DPUT;
          end
        end
        ST_DPUT: begin
          st    <= ST_IDLE;
          cnt   <= cnt - CNT_W'(WORD_BYTES);
          baddr <= baddr + ADDR_W'(WORD_BYTES);
        end
        ST_DGET: begin
          st       <= ST_MWR;
          mem_req  <= 1'b1;
          mem_we   <= 1'b1;
          mem_addr <= baddr;
        end
        ST_MWR: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            mem_we  <= 1'b0;
            st      <= ST_IDLE;
            cnt     <= cnt - CNT_W'(WORD_BYTES);
            baddr   <= baddr + ADDR_W'(WORD_BYTES);
          end
        end
        default: st <= ST_IDLE;
      endcase
      if (start) begin
        cnt  <= '0;
        dptr <= tbl_ptr;
      end
    end
  end
endmodule

// File: rtl/desc_dma_engine.sv
module desc_dma_engine
  import dde_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [7:0]        cmd_reg,
  output logic [7:0]        sts_reg,
  output logic [ADDR_W-1:0] tbl_reg,
  input  logic              drive_irq,
  input  logic              drv_req,
  output logic              drv_ack,
  input  logic [DATA_W-1:0] drv_rdata,
  output logic [DATA_W-1:0] drv_wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack
);
  logic start_pulse, active, to_mem, xfer_done;

  dde_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .drive_irq   (drive_irq),
    .xfer_done   (xfer_done),
    .cmd_q       (cmd_reg),
    .sts_q       (sts_reg),
    .tbl_q       (tbl_reg),
    .start_pulse (start_pulse),
    .active      (active),
    .to_mem      (to_mem)
  );

  dde_mover #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mover (
    .clk       (clk),
    .rst       (rst),
    .start     (start_pulse),
    .active    (active),
    .to_mem    (to_mem),
    .tbl_ptr   (tbl_reg),
    .drv_req   (drv_req),
    .drv_rdata (drv_rdata),
    .drv_ack   (drv_ack),
    .drv_wdata (drv_wdata),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_ack   (mem_ack),
    .done      (xfer_done)
  );
endmodule

// File: rtl/dde_chk.sv
module dde_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [1:0]        reg_addr,
  input logic              wr_bit0,
  input logic [7:0]        cmd_reg,
  input logic [7:0]        sts_reg,
  input logic              drive_irq,
  input logic              drv_ack,
  input logic              mem_req,
  input logic              mem_ack,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata
);
  // R13
  mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R9
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    drv_ack |=> !drv_ack);

  // R9
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(drv_ack && mem_req));

  // R4
  irq_edge_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(drive_irq) |=> sts_reg[2]);

  // R2
  start_active_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 2'd0 && wr_bit0 && !cmd_reg[0]) |=> sts_reg[0]);
endmodule

bind desc_dma_engine dde_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .wr_bit0   (reg_wdata[0]),
  .cmd_reg   (cmd_reg),
  .sts_reg   (sts_reg),
  .drive_irq (drive_irq),
  .drv_ack   (drv_ack),
  .mem_req   (mem_req),
  .mem_ack   (mem_ack),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata)
);

// File: tb/desc_dma_engine_tb.sv
module desc_dma_engine_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [7:0]  cmd_reg, sts_reg;
  logic [31:0] tbl_reg;
  logic        drive_irq = 1'b0;
  logic        drv_req = 1'b0;
  logic        drv_ack;
  logic [15:0] src_word = 16'h5A00;
  logic [15:0] drv_wdata;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;

  logic [15:0] mem [0:1023];
  logic [15:0] rd_q [$];
  logic [47:0] wr_q [$];
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  desc_dma_engine u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .cmd_reg(cmd_reg), .sts_reg(sts_reg), .tbl_reg(tbl_reg), .drive_irq(drive_irq),
    .drv_req(drv_req), .drv_ack(drv_ack), .drv_rdata(src_word), .drv_wdata(drv_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  // Memory model: acknowledges one cycle after a request
  always @(posedge clk) begin
    if (rst) mem_ack <= 1'b0;
    else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_ack && mem_we) mem[mem_addr[10:1]] <= mem_wdata;
      mem_rdata <= mem[mem_addr[10:1]];
    end
  end

  // Drive model: next word after each strobe in drive-to-memory mode
  always @(negedge clk) if (!rst && drv_ack && cmd_reg[3]) src_word <= src_word + 16'd1;

  task automatic check(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (drv_ack && !cmd_reg[3]) begin
        if (rd_q.size() == 0) check(1'b0, "R9 unexpected drive word", {32'd0, drv_wdata}, 48'd0);
        else begin
          logic [15:0] e;
          e = rd_q.pop_front();
          check(drv_wdata == e, "R9 drive word", {32'd0, drv_wdata}, {32'd0, e});
        end
      end
      if (mem_req && mem_we && mem_ack) begin
        if (wr_q.size() == 0) check(1'b0, "R10 unexpected memory write", {mem_addr, mem_wdata}, 48'd0);
        else begin
          logic [47:0] e;
          e = wr_q.pop_front();
          check({mem_addr, mem_wdata} == e, "R10 memory write", {mem_addr, mem_wdata}, e);
        end
      end
    end
  end

  task automatic wr_reg(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic put_desc(input int base, input logic [31:0] a, input logic [15:0] len, input bit fin);
    mem[(base >> 1) + 0] = a[15:0];
    mem[(base >> 1) + 1] = a[31:16];
    mem[(base >> 1) + 2] = len;
    mem[(base >> 1) + 3] = fin ? 16'h8000 : 16'h0000;
  endtask

  // Counts strobes; drops the drive request on the n-th
  task automatic take_strobes(input int n);
    int seen = 0;
    for (int c = 0; c < 5000 && seen < n; c++) begin
      @(negedge clk);
      if (drv_ack) begin
        seen++;
        if (seen == n) drv_req = 1'b0;
      end
    end
    check(seen == n, "strobe count", 48'(seen), 48'(n));
  endtask

  task automatic count_acks(input int cyc, output int c);
    c = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (drv_ack || mem_req) c++;
    end
  endtask

  task automatic wait_idle(input string tag);
    int c = 0;
    while (sts_reg[0] && c < 5000) begin @(negedge clk); c++; end
    check(!sts_reg[0], tag, 48'(sts_reg), 48'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", 48'd0, 48'd1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    for (int i = 0; i < 1024; i++) mem[i] = 16'hA000 + 16'(i);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // Reset state
    check(cmd_reg == 8'h00, "R1 reset command", 48'(cmd_reg), 48'h0);
    check(sts_reg == 8'h00, "R5 reset status", 48'(sts_reg), 48'h0);
    check(tbl_reg == 32'h0, "R6 reset pointer", 48'(tbl_reg), 48'h0);
    check(!mem_req && !drv_ack, "R11 reset idle", {46'd0, mem_req, drv_ack}, 48'h0);

    // R6
    wr_reg(2'd2, 32'h0000_0103);
    check(tbl_reg == 32'h100, "R6 pointer low bits", 48'(tbl_reg), 48'h100);
    // R1
    wr_reg(2'd0, 32'hF6);
    check(cmd_reg == 8'h00, "R1 masked command bits", 48'(cmd_reg), 48'h0);
    // R5
    wr_reg(2'd1, 32'hFF);
    check(sts_reg == 8'h60, "R5 capability bits and ignored active", 48'(sts_reg), 48'h60);
    wr_reg(2'd1, 32'h00);
    check(sts_reg == 8'h00, "R5 capability cleared", 48'(sts_reg), 48'h0);

    // R4 pulse, clear, held level
    @(negedge clk); drive_irq = 1'b1; @(negedge clk); drive_irq = 1'b0; @(negedge clk);
    check(sts_reg[2], "R4 interrupt pulse", 48'(sts_reg), 48'h4);
    wr_reg(2'd1, 32'h04);
    check(!sts_reg[2], "R4 write one clears", 48'(sts_reg), 48'h0);
    drive_irq = 1'b1; repeat (2) @(negedge clk);
    wr_reg(2'd1, 32'h04);
    repeat (4) @(negedge clk);
    check(!sts_reg[2], "R4 held level no re-set", 48'(sts_reg), 48'h0);
    drive_irq = 1'b0;

    // R7 R9 R12: two-entry read chain
    put_desc(32'h100, 32'h0000_0201, 16'd7, 1'b0);
    put_desc(32'h108, 32'h0000_0300, 16'd4, 1'b1);
    rd_q.push_back(mem[9'h100]); rd_q.push_back(mem[9'h101]); rd_q.push_back(mem[9'h102]);
    rd_q.push_back(mem[9'h180]); rd_q.push_back(mem[9'h181]);
    drv_req = 1'b1;
    wr_reg(2'd0, 32'h01);
    check(sts_reg[0], "R2 start sets active", 48'(sts_reg), 48'h1);
    wait_idle("R12 active clears at end of chain");
    check(rd_q.size() == 0, "R7 all chain words delivered", 48'(rd_q.size()), 48'h0);
    count_acks(20, n);
    check(n == 0, "R12 no activity after end", 48'(n), 48'h0);
    drv_req = 1'b0;
    wr_reg(2'd0, 32'h00);

    // R3 abort, then R2 restart replays from the table pointer
    put_desc(32'h100, 32'h0000_0200, 16'd64, 1'b1);
    rd_q.push_back(mem[9'h100]); rd_q.push_back(mem[9'h101]); rd_q.push_back(mem[9'h102]);
    drv_req = 1'b1;
    wr_reg(2'd0, 32'h01);
    take_strobes(3);
    repeat (10) @(negedge clk);
    wr_reg(2'd0, 32'h00);
    check(sts_reg == 8'h00, "R3 abort clears active, no error", 48'(sts_reg), 48'h0);
    drv_req = 1'b1;
    count_acks(20, n);
    check(n == 0, "R3 no strobes after abort", 48'(n), 48'h0);
    rd_q.push_back(mem[9'h100]); rd_q.push_back(mem[9'h101]);
    wr_reg(2'd0, 32'h01);
    take_strobes(2);
    repeat (10) @(negedge clk);
    wr_reg(2'd0, 32'h00);
    check(rd_q.size() == 0, "R2 restart reloads pointer", 48'(rd_q.size()), 48'h0);

    // R10 R11: drive-to-memory with a pause
    put_desc(32'h120, 32'h0000_0501, 16'd8, 1'b1);
    wr_reg(2'd2, 32'h120);
    for (int k = 0; k < 4; k++) wr_q.push_back({32'h500 + 32'(2 * k), 16'h5A00 + 16'(k)});
    drv_req = 1'b0;
    wr_reg(2'd0, 32'h09);
    check(cmd_reg == 8'h09, "R1 run and direction bits", 48'(cmd_reg), 48'h9);
    count_acks(20, n);
    check(n == 0 && wr_q.size() == 4, "R11 idle without drive request", 48'(n), 48'h0);
    drv_req = 1'b1;
    take_strobes(2);
    repeat (20) @(negedge clk);
    check(wr_q.size() == 2, "R11 paused after two words", 48'(wr_q.size()), 48'h2);
    drv_req = 1'b1;
    wait_idle("R12 write chain ends");
    drv_req = 1'b0;
    check(wr_q.size() == 0, "R10 all words written", 48'(wr_q.size()), 48'h0);
    check(mem[10'h283] == 16'h5A03, "R10 last word in memory", 48'(mem[10'h283]), 48'h5A03);
    wr_reg(2'd0, 32'h00);

    // R8: zero length is the maximum
    put_desc(32'h140, 32'h0000_0400, 16'd0, 1'b1);
    wr_reg(2'd2, 32'h140);
    for (int k = 0; k < 40; k++) rd_q.push_back(mem[10'h200 + 10'(k)]);
    drv_req = 1'b1;
    wr_reg(2'd0, 32'h01);
    take_strobes(40);
    repeat (10) @(negedge clk);
    check(sts_reg[0], "R8 zero length still active", 48'(sts_reg), 48'h1);
    wr_reg(2'd0, 32'h00);
    check(rd_q.size() == 0, "R8 words from zero-length entry", 48'(rd_q.size()), 48'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule